// File: doc/BRIEF.md
# Dynamic Frequency Select Controller

This block decides which of four stored PLL feedback-divider words drives the PLL. It then moves the applied word toward the chosen one in small steps, so the VCO slides to its new frequency without overshoot or undershoot.

The 2-bit selection comes from a fixed priority scheme:
- An enable bit can force selection 0.
- Each of two control pins carries a 2-bit function field. When a field holds the code `11`, that pin becomes a selection pin.
- When neither pin is a selection pin, a strap captured once after reset release decides the source:
  - strap low: the two serial-bus pin levels give the selection;
  - strap high: a register field gives the selection.

A write port, steered by a separate 2-bit configuration pointer, loads the four divider words. The PLL, the non-volatile store and the serial protocol engine sit outside this block.

While the applied word differs from the selected target, the block adds or subtracts a programmable step once every `TICK` clock cycles. The last step clamps exactly onto the target. If the selection changes mid-ramp, the new target takes effect at once and the ramp carries on from the present applied value.

Top module: `dfs_ctrl`

## Requirements
- R1: With `en_i` low, the selection `sel_o` becomes 2'b00 on the next clock edge, whatever the other select inputs are.
- R2: With `en_i` high, `pin_a_fn_i` == 2'b11 and `pin_b_fn_i` != 2'b11, the selection becomes {1'b0, `pin_a_i`} on the next clock edge.
- R3: With `en_i` high and both function fields equal to 2'b11, the selection becomes {`pin_b_i`, `pin_a_i`} on the next clock edge.
- R4: With `en_i` high, `pin_a_fn_i` != 2'b11 and `pin_b_fn_i` == 2'b11, `illegal_o` is 1 and `sel_o` keeps its last value. In every other case `illegal_o` is 0.
- R5: With `en_i` high, neither field equal to 2'b11 and the strap captured low, the selection becomes {`scl_i`, `sda_i`}.
- R6: With `en_i` high, neither field equal to 2'b11 and the strap captured high, the selection becomes `reg_sel_i`.
- R7: `strap_i` is captured on the first clock edge after reset release. Later changes of `strap_i` have no effect until the next reset.
- R8: A clock edge with `wr_en_i` high stores `wr_data_i` into word `wr_cfg_sel_i`. An edge with `wr_en_i` low changes no word. After reset, every word and `div_o` equal `RST_DIV` (default 16'h0100).
- R9: While `div_o` differs from the selected word, `div_o` moves toward that word by the step once every `TICK` cycles (default 4). It never passes the target, and the final move lands exactly on it.
- R10: `busy_o` is 1 exactly when `div_o` differs from the selected word. When they are equal, `div_o` holds.
- R11: A selection change during a ramp retargets at once. The ramp continues from the present `div_o` with its step cadence unbroken.
- R12: A `step_i` value of 0 is treated as a step of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Function enable |
| pin_a_fn_i | input | 2 | Function field of control pin A (2'b11 = selection pin) |
| pin_b_fn_i | input | 2 | Function field of control pin B (2'b11 = selection pin) |
| pin_a_i | input | 1 | Level of control pin A |
| pin_b_i | input | 1 | Level of control pin B |
| strap_i | input | 1 | Mode strap, captured after reset release |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| reg_sel_i | input | 2 | Register-driven selection |
| wr_cfg_sel_i | input | 2 | Configuration targeted by writes |
| wr_en_i | input | 1 | Divider-word write strobe |
| wr_data_i | input | DIV_W | Divider word to write |
| step_i | input | STEP_W | Ramp step size |
| sel_o | output | 2 | Active selection |
| div_o | output | DIV_W | Divider word currently applied |
| busy_o | output | 1 | Ramp in progress |
| illegal_o | output | 1 | Forbidden function-field combination |

## Verification
The assertions assume that all inputs are synchronous to `clk_i`, and that `strap_i` is stable while reset is asserted and on the first edge after release. They also assume that `TICK` is at least 2, so that the step cadence and the retarget rule can be told apart. The stimulus changes every input on the falling edge. It holds the strap steady through each reset, and it moves the strap only after the capture edge when it tests that later strap changes are ignored. The reference values for each ramp are computed from the old word, the new word and the step, then compared against every change of `div_o`. The time between steps is checked as well.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int unsigned N_CFG = 4;
  localparam int unsigned SEL_W = 2;
  localparam logic [1:0] FN_SEL = 2'b11;

  typedef enum logic [1:0] {
    SRC_OFF,
    SRC_PIN,
    SRC_BUS,
    SRC_REG
  } src_e;
endpackage

// File: rtl/dfs_sel.sv
module dfs_sel
  import dfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       fn_a_i,
  input  logic [1:0]       fn_b_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             strap_i,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             illegal_o
);
  logic             strap_q, strap_done_q;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             bad;
  src_e             src;

  // strap captured once on first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= 1'b1;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_i;
      strap_done_q <= 1'b1;
    end
  end

  always_comb begin
    bad = 1'b0;
    src = SRC_OFF;
    if (en_i) begin
      if (fn_a_i == FN_SEL)      src = SRC_PIN;
      else if (fn_b_i == FN_SEL) bad = 1'b1;
      else if (!strap_q)         src = SRC_BUS;
      else                       src = SRC_REG;
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (!bad) begin
      unique case (src)
        SRC_OFF: sel_d = '0;
        SRC_PIN: sel_d = {(fn_b_i == FN_SEL) ? pin_b_i : 1'b0, pin_a_i};
        SRC_BUS: sel_d = {scl_i, sda_i};
        SRC_REG: sel_d = reg_sel_i;
        default: sel_d = sel_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign sel_o     = sel_q;
  assign illegal_o = bad;

  // R1
  sel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sel_q == '0));
  // R4
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(sel_q));
  // R7
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> $stable(strap_q));
endmodule

// File: rtl/dfs_cfg_bank.sv
module dfs_cfg_bank
  import dfs_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter logic [DIV_W-1:0] RST_DIV = 16'h0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [DIV_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [DIV_W-1:0] rd_data_o
);
  logic [N_CFG-1:0][DIV_W-1:0] words_q;

  for (genvar g = 0; g < N_CFG; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        words_q[g] <= RST_DIV;
      else if (wr_en_i && (wr_sel_i == SEL_W'(g)))
        words_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = words_q[rd_sel_i];

  // R8
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(words_q));
endmodule

// File: rtl/dfs_ramp.sv
module dfs_ramp #(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned TICK    = 4,
  parameter logic [DIV_W-1:0] RST_DIV = 16'h0100,
  localparam int unsigned CNT_W  = (TICK > 1) ? $clog2(TICK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  tgt_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              busy_o
);
  logic [DIV_W-1:0] div_q, div_d, st, gap;
  logic [CNT_W-1:0] cnt_q;
  logic             busy, up, fire;

  assign st   = (step_i == '0) ? DIV_W'(1) : DIV_W'(step_i);
  assign busy = (div_q != tgt_i);
  assign up   = (tgt_i > div_q);
  assign gap  = up ? (tgt_i - div_q) : (div_q - tgt_i);
  assign fire = busy && (cnt_q == CNT_W'(TICK - 1));

  always_comb begin
    div_d = div_q;
    if (fire) begin
      if (gap <= st) div_d = tgt_i;
      else if (up)   div_d = div_q + st;
      else           div_d = div_q - st;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= RST_DIV;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      if (!busy || fire) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_o  = div_q;
  assign busy_o = busy;

  // R9
  no_overshoot_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_q) < $past(tgt_i)) |-> (div_q <= $past(tgt_i)));
  // R9
  no_overshoot_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(div_q) > $past(tgt_i)) |-> (div_q >= $past(tgt_i)));
  // R9
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q > $past(div_q)) |-> ((div_q - $past(div_q)) <= $past(st)));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == tgt_i) |=> (div_q == $past(div_q)));
endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned STEP_W  = 8,
  parameter int unsigned TICK    = 4,
  parameter logic [DIV_W-1:0] RST_DIV = 16'h0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        pin_a_fn_i,
  input  logic [1:0]        pin_b_fn_i,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              strap_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [1:0]        wr_cfg_sel_i,
  input  logic              wr_en_i,
  input  logic [DIV_W-1:0]  wr_data_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [1:0]        sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              busy_o,
  output logic              illegal_o
);
  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] tgt;

  dfs_sel u_sel (
    .clk_i, .rst_ni, .en_i,
    .fn_a_i   (pin_a_fn_i),
    .fn_b_i   (pin_b_fn_i),
    .pin_a_i, .pin_b_i, .strap_i, .scl_i, .sda_i, .reg_sel_i,
    .sel_o    (sel),
    .illegal_o
  );

  dfs_cfg_bank #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_bank (
    .clk_i, .rst_ni, .wr_en_i,
    .wr_sel_i  (wr_cfg_sel_i),
    .wr_data_i,
    .rd_sel_i  (sel),
    .rd_data_o (tgt)
  );

  dfs_ramp #(.DIV_W(DIV_W), .STEP_W(STEP_W), .TICK(TICK), .RST_DIV(RST_DIV)) u_ramp (
    .clk_i, .rst_ni,
    .tgt_i  (tgt),
    .step_i,
    .div_o,
    .busy_o
  );

  assign sel_o = sel;
endmodule

// File: tb/dfs_ctrl_tb.sv
`timescale 1ns/1ps
module dfs_ctrl_tb;
  localparam int TICK = 4;
  logic clk_i = 0, rst_ni = 0;
  logic en_i = 0, pin_a_i = 0, pin_b_i = 0, strap_i = 0, scl_i = 0, sda_i = 0, wr_en_i = 0;
  logic [1:0] pin_a_fn_i = 0, pin_b_fn_i = 0, reg_sel_i = 0, wr_cfg_sel_i = 0;
  logic [15:0] wr_data_i = 0;
  logic [7:0] step_i = 8'h10;
  logic [1:0] sel_o;
  logic [15:0] div_o;
  logic busy_o, illegal_o;

  int checks = 0, errors = 0, cyc = 0, last_chg = 0;
  logic [15:0] exp_q[$];
  bit gap_q[$];
  logic [15:0] prev_div = 16'h0100, cur = 16'h0100;

  always #4 clk_i = ~clk_i;

  dfs_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every change of div_o against the scoreboard
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && div_o !== prev_div) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected", div_o, prev_div);
      else begin
        logic [15:0] e;
        bit g;
        e = exp_q.pop_front();
        g = gap_q.pop_front();
        chk(div_o === e, "R9 ramp value", div_o, e);
        if (g) chk(cyc - last_chg == TICK, "R9/R11 cadence", cyc - last_chg, TICK);
      end
      last_chg = cyc;
    end
    prev_div = div_o;
  end

  // driver side: push expected ramp values, up to maxn of them
  task automatic push_ramp(input logic [15:0] tgt, input int maxn, input bit first_gap);
    int n = 0;
    logic [15:0] st;
    st = (step_i == 0) ? 16'd1 : 16'(step_i);
    while (cur != tgt && n < maxn) begin
      if (tgt > cur) cur = (tgt - cur <= st) ? tgt : cur + st;
      else           cur = (cur - tgt <= st) ? tgt : cur - st;
      exp_q.push_back(cur);
      gap_q.push_back(n == 0 ? first_gap : 1'b1);
      n++;
    end
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0) break;
    end
  endtask

  task automatic wait_idle(input string req);
    wait_drain();
    @(negedge clk_i);
    chk(exp_q.size() == 0, {req, " drained"}, exp_q.size(), 0);
    chk(div_o === cur && busy_o === 1'b0, {req, " R10 settled"}, div_o, cur);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d, input logic en);
    @(negedge clk_i);
    wr_cfg_sel_i = idx; wr_data_i = d; wr_en_i = en;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 0; strap_i = strap; en_i = 0;
    exp_q.delete(); gap_q.delete();
    cur = 16'h0100;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    prev_div = div_o;
  endtask

  task automatic load_words();
    wr(2'd1, 16'h0180, 1);
    wr(2'd2, 16'h00F5, 1);
    wr(2'd3, 16'h0200, 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // phase 1: strap low -> serial pins select
    do_reset(1'b0);
    chk(sel_o === 2'b00, "R1 reset sel", sel_o, 0);
    chk(div_o === 16'h0100 && busy_o === 0, "R8 reset div", div_o, 16'h0100);
    chk(illegal_o === 0, "R4 reset illegal", illegal_o, 0);
    load_words();
    wr(2'd0, 16'h0777, 0);  // strobe low: must be ignored
    @(negedge clk_i);
    en_i = 1; scl_i = 0; sda_i = 1;
    push_ramp(16'h0180, 1000, 0);
    @(negedge clk_i);
    chk(sel_o === 2'b01, "R5 bus select", sel_o, 1);
    chk(busy_o === 1, "R10 busy on", busy_o, 1);
    wait_idle("R9 up");
    en_i = 0;
    push_ramp(16'h0100, 1000, 0);  // word 0 still reset value (R8)
    @(negedge clk_i);
    chk(sel_o === 2'b00, "R1 disable", sel_o, 0);
    wait_idle("R8 word0 unchanged");

    // phase 2: strap high, then moved low after capture
    do_reset(1'b1);
    @(negedge clk_i);
    strap_i = 0;
    load_words();
    @(negedge clk_i);
    en_i = 1; reg_sel_i = 2'd2; scl_i = 1; sda_i = 1;
    push_ramp(16'h00F5, 1000, 0);
    @(negedge clk_i);
    chk(sel_o === 2'b10, "R6/R7 register select", sel_o, 2);
    wait_idle("R9 clamp down");
    reg_sel_i = 2'd3;
    push_ramp(16'h0200, 3, 0);
    wait_drain();
    reg_sel_i = 2'd1;  // retarget mid-ramp
    push_ramp(16'h0180, 1000, 1);
    @(negedge clk_i);
    chk(sel_o === 2'b01, "R11 retarget sel", sel_o, 1);
    wait_idle("R11 retarget");

    pin_a_fn_i = 2'b11; pin_b_fn_i = 2'b00; pin_a_i = 0; pin_b_i = 1;
    push_ramp(16'h0100, 1000, 0);
    @(negedge clk_i);
    chk(sel_o === 2'b00, "R2 one pin low", sel_o, 0);
    wait_idle("R2 ramp");
    pin_a_i = 1;
    push_ramp(16'h0180, 1000, 0);
    @(negedge clk_i);
    chk(sel_o === 2'b01, "R2 one pin high", sel_o, 1);
    wait_idle("R2 ramp up");

    pin_b_fn_i = 2'b11; pin_a_i = 0; pin_b_i = 1;
    push_ramp(16'h00F5, 1000, 0);
    @(negedge clk_i);
    chk(sel_o === 2'b10, "R3 two pin", sel_o, 2);
    wait_idle("R3 ramp");

    pin_a_fn_i = 2'b01; pin_a_i = 1; pin_b_i = 1;
    @(negedge clk_i);
    chk(illegal_o === 1, "R4 illegal flag", illegal_o, 1);
    repeat (3) @(negedge clk_i);
    chk(sel_o === 2'b10, "R4 sel held", sel_o, 2);
    chk(div_o === cur && busy_o === 0, "R4 div held", div_o, cur);

    wr(2'd0, 16'h00F8, 1);
    step_i = 8'h00;
    pin_a_fn_i = 2'b11; pin_b_fn_i = 2'b00; pin_a_i = 0;
    push_ramp(16'h00F8, 1000, 0);
    @(negedge clk_i);
    chk(illegal_o === 0, "R4 illegal clear", illegal_o, 0);
    chk(sel_o === 2'b00, "R12 sel", sel_o, 0);
    wait_idle("R12 zero step");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule